// File: doc/BRIEF.md
# Destination Address Hash Filter

The filter decides whether a received frame is for this station by looking only at the frame's 6-byte destination address. The address arrives one byte per cycle. The first byte is flagged with a start strobe, and idle cycles may appear between bytes. One cycle after the sixth byte, the filter raises a single-cycle decision strobe and an accept flag.

There are three ways to accept a frame:
- **Promiscuous mode:** if the promiscuous bit is set, every frame is accepted.
- **Unicast:** an address whose first byte has bit 0 clear must equal the programmed station address in all 48 bits.
- **Multicast and broadcast:** an address whose first byte has bit 0 set is looked up in a 64-bit hash table. A bit-reflected CRC-32 is computed over the six address bytes, and its six most significant bits index the table.

Software programs the station address, the mode and the table as 16-bit words through a simple write port. No other setup is needed.

Top module: `dest_addr_filter`

## Requirements
- R1: After reset `dec_valid` and `dec_accept` are low. The station address, promiscuous bit and hash table all reset to zero, so an all-zero unicast address is accepted and any multicast address is rejected.
- R2: `dec_valid` is high for exactly one cycle, in the cycle after the clock edge that captures the sixth address byte. `dec_accept` is never high while `dec_valid` is low.
- R3: A unicast frame (byte 0 bit 0 clear) is accepted only when all six bytes equal the station address.
  - Station word k (k = 0..2) holds address byte 2k in bits 7:0 and byte 2k+1 in bits 15:8.
- R4: A multicast frame (byte 0 bit 0 set, broadcast included) is accepted only when the table bit selected by its hash is set. The station address plays no part.
  - The CRC uses polynomial 0xEDB88320 in shifted-right form. It starts at all ones and shifts each byte in LSB first.
  - The hash is bits 31:26 of the CRC after the sixth byte, with no final inversion.
  - Hash bits 5:4 select table word 0..3, and hash bits 3:0 select the bit within that word.
- R5: With the promiscuous bit (mode word bit 0) set, every frame is accepted whatever its address and the table.
- R6: A table of all ones accepts every multicast frame and has no effect on unicast decisions.
- R7: Writes with `cfg_we` select their target by `cfg_addr`:
  - 0 to 2: station words.
  - 3: mode word.
  - 4 to 7: table words 0 to 3.
  - A write takes effect at its clock edge. A decision made at that same edge still uses the previous value.
- R8: A byte with `byte_sof` set always starts a new address, discarding any partial one. Cycles with `byte_valid` low inside an address are skipped. Bytes without `byte_sof` arriving while no address is in progress are ignored.
- R9: Bytes after the sixth and before the next `byte_sof` produce no further decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration word select |
| cfg_wdata | input | 16 | Configuration write data |
| byte_valid | input | 1 | Address byte present this cycle |
| byte_sof | input | 1 | Marks the first address byte |
| byte_data | input | 8 | Address byte |
| dec_valid | output | 1 | Decision strobe, one cycle |
| dec_accept | output | 1 | Frame accepted, qualified by dec_valid |

## Verification
Unicast addresses are tried as exact matches and as matches differing only in the first byte or only in the last byte. This separates a full 48-bit compare from a partial one, and a wrong byte order in the station words from a right one.

Multicast and broadcast addresses are run against three kinds of table:
- a table with only the computed hash bit set,
- a table with every bit but that one set,
- an all-ones table.

The first two together tell apart a wrong word or bit selection, a wrong CRC seed and a wrong reflection.

Frames with idle gaps, aborted prefixes, trailing bytes, promiscuous mode, and a table write landing on the sixth byte show whether stalls, restarts, extra bytes, the mode bit and write timing are handled as specified.

// File: rtl/daf_pkg.sv
package daf_pkg;

   localparam int BYTE_W = 8;
   localparam int CRC_W  = 32;

   // one byte of a right-shifting (bit-reflected) CRC
   function automatic logic [CRC_W-1:0] crc_step(
      input logic [CRC_W-1:0]  crc_in,
      input logic [BYTE_W-1:0] din,
      input logic [CRC_W-1:0]  poly
   );
      logic [CRC_W-1:0] c;
      c = crc_in ^ {{(CRC_W-BYTE_W){1'b0}}, din};
      for (int k = 0; k < BYTE_W; k++) begin
         c = c[0] ? ((c >> 1) ^ poly) : (c >> 1);
      end
      return c;
   endfunction

endpackage

// File: rtl/daf_cfg_regs.sv
module daf_cfg_regs #(
   parameter int WORD_W    = 16,
   parameter int STA_WORDS = 3,
   parameter int TBL_WORDS = 4,
   parameter int CFG_AW    = 3
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          cfg_we,
   input  logic [CFG_AW-1:0]             cfg_addr,
   input  logic [WORD_W-1:0]             cfg_wdata,
   output logic [STA_WORDS*WORD_W-1:0]   sta_o,
   output logic                          promisc_o,
   output logic [TBL_WORDS*WORD_W-1:0]   tbl_o
);

   localparam int MODE_IDX = STA_WORDS;
   localparam int TBL_BASE = STA_WORDS + 1;

   genvar k;
   generate
      for (k = 0; k < STA_WORDS; k++) begin : g_sta
         logic [WORD_W-1:0] w_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               w_q <= '0;
            else if (cfg_we && cfg_addr == CFG_AW'(k))
               w_q <= cfg_wdata;
         end
         assign sta_o[k*WORD_W +: WORD_W] = w_q;
      end

      for (k = 0; k < TBL_WORDS; k++) begin : g_tbl
         logic [WORD_W-1:0] w_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               w_q <= '0;
            else if (cfg_we && cfg_addr == CFG_AW'(TBL_BASE + k))
               w_q <= cfg_wdata;
         end
         assign tbl_o[k*WORD_W +: WORD_W] = w_q;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         promisc_o <= 1'b0;
      else if (cfg_we && cfg_addr == CFG_AW'(MODE_IDX))
         promisc_o <= cfg_wdata[0];
   end

endmodule

// File: rtl/daf_addr_hash.sv
module daf_addr_hash
   import daf_pkg::*;
#(
   parameter int          ADDR_BYTES = 6,
   parameter int          HASH_BITS  = 6,
   parameter logic [31:0] CRC_POLY   = 32'hEDB88320
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         byte_valid,
   input  logic                         byte_sof,
   input  logic [BYTE_W-1:0]            byte_data,
   output logic                         last_o,
   output logic [ADDR_BYTES*BYTE_W-1:0] addr_o,
   output logic [HASH_BITS-1:0]         hash_o
);

   localparam int CNT_W = $clog2(ADDR_BYTES + 1);
   localparam logic [CRC_W-1:0] CRC_SEED = '1;

   logic [CNT_W-1:0] cnt_q;      // bytes taken; ADDR_BYTES means idle
   logic [CRC_W-1:0] crc_q;
   logic [CRC_W-1:0] crc_nx;
   logic             take;

   assign take   = byte_valid && (byte_sof || cnt_q < CNT_W'(ADDR_BYTES));
   assign last_o = byte_valid &&
                   (byte_sof ? (ADDR_BYTES == 1) : (cnt_q == CNT_W'(ADDR_BYTES - 1)));
   assign crc_nx = crc_step(byte_sof ? CRC_SEED : crc_q, byte_data, CRC_POLY);
   assign hash_o = crc_nx[CRC_W-1 -: HASH_BITS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= CNT_W'(ADDR_BYTES);
         crc_q <= CRC_SEED;
      end else if (take) begin
         cnt_q <= byte_sof ? CNT_W'(1) : cnt_q + CNT_W'(1);
         crc_q <= crc_nx;
      end
   end

   genvar i;
   generate
      for (i = 0; i < ADDR_BYTES; i++) begin : g_slot
         logic [BYTE_W-1:0] b_q;
         logic              wr;
         assign wr = byte_valid &&
                     ((byte_sof && i == 0) || (!byte_sof && cnt_q == CNT_W'(i)));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               b_q <= '0;
            else if (wr)
               b_q <= byte_data;
         end
         if (i == ADDR_BYTES - 1) begin : g_bypass
            assign addr_o[i*BYTE_W +: BYTE_W] = last_o ? byte_data : b_q;
         end else begin : g_held
            assign addr_o[i*BYTE_W +: BYTE_W] = b_q;
         end
      end
   endgenerate

endmodule

// File: rtl/daf_decide.sv
module daf_decide #(
   parameter int ADDR_W    = 48,
   parameter int HASH_BITS = 6,
   parameter int WORD_W    = 16,
   parameter int TBL_WORDS = 4
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        last_i,
   input  logic [ADDR_W-1:0]           addr_i,
   input  logic [HASH_BITS-1:0]        hash_i,
   input  logic [ADDR_W-1:0]           sta_i,
   input  logic                        promisc_i,
   input  logic [TBL_WORDS*WORD_W-1:0] tbl_i,
   output logic                        dec_valid,
   output logic                        dec_accept
);

   localparam int BIT_W  = $clog2(WORD_W);
   localparam int WIDX_W = HASH_BITS - BIT_W;

   logic tbl_hit;
   logic sta_hit;
   logic group;
   logic accept_c;

   generate
      if (TBL_WORDS == 1) begin : g_flat
         assign tbl_hit = tbl_i[hash_i[BIT_W-1:0]];
      end else begin : g_words
         logic [WORD_W-1:0] word_sel;
         logic [WIDX_W-1:0] widx;
         assign widx     = hash_i[HASH_BITS-1 -: WIDX_W];
         assign word_sel = tbl_i[widx*WORD_W +: WORD_W];
         assign tbl_hit  = word_sel[hash_i[BIT_W-1:0]];
      end
   endgenerate

   assign group    = addr_i[0];
   assign sta_hit  = (addr_i == sta_i);
   assign accept_c = promisc_i || (group ? tbl_hit : sta_hit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dec_valid  <= 1'b0;
         dec_accept <= 1'b0;
      end else begin
         dec_valid  <= last_i;
         dec_accept <= last_i && accept_c;
      end
   end

endmodule

// File: rtl/dest_addr_filter.sv
module dest_addr_filter #(
   parameter int          ADDR_BYTES = 6,
   parameter int          WORD_W     = 16,
   parameter int          HASH_BITS  = 6,
   parameter int          CFG_AW     = 3,
   parameter logic [31:0] CRC_POLY   = 32'hEDB88320
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [CFG_AW-1:0] cfg_addr,
   input  logic [WORD_W-1:0] cfg_wdata,
   input  logic              byte_valid,
   input  logic              byte_sof,
   input  logic [7:0]        byte_data,
   output logic              dec_valid,
   output logic              dec_accept
);

   localparam int ADDR_W    = ADDR_BYTES * 8;
   localparam int STA_WORDS = ADDR_W / WORD_W;
   localparam int TBL_BITS  = 1 << HASH_BITS;
   localparam int TBL_WORDS = TBL_BITS / WORD_W;
   localparam int CFG_WORDS = STA_WORDS + 1 + TBL_WORDS;

   generate
      if (ADDR_W % WORD_W != 0) begin : g_chk_sta
         $error("address width must be a whole number of config words");
      end
      if (TBL_BITS % WORD_W != 0 || HASH_BITS < $clog2(WORD_W)) begin : g_chk_tbl
         $error("hash table must be a whole number of config words");
      end
      if (HASH_BITS > 32 || HASH_BITS < 1) begin : g_chk_hash
         $error("hash width must fit the CRC register");
      end
      if ((1 << CFG_AW) < CFG_WORDS) begin : g_chk_cfg
         $error("config address too narrow for the word map");
      end
   endgenerate

   logic                        last_w;
   logic [ADDR_W-1:0]           addr_w;
   logic [HASH_BITS-1:0]        hash_w;
   logic [ADDR_W-1:0]           sta_w;
   logic                        promisc_w;
   logic [TBL_WORDS*WORD_W-1:0] tbl_w;

   daf_cfg_regs #(
      .WORD_W   (WORD_W),
      .STA_WORDS(STA_WORDS),
      .TBL_WORDS(TBL_WORDS),
      .CFG_AW   (CFG_AW)
   ) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_we   (cfg_we),
      .cfg_addr (cfg_addr),
      .cfg_wdata(cfg_wdata),
      .sta_o    (sta_w),
      .promisc_o(promisc_w),
      .tbl_o    (tbl_w)
   );

   daf_addr_hash #(
      .ADDR_BYTES(ADDR_BYTES),
      .HASH_BITS (HASH_BITS),
      .CRC_POLY  (CRC_POLY)
   ) u_hash (
      .clk       (clk),
      .rst_n     (rst_n),
      .byte_valid(byte_valid),
      .byte_sof  (byte_sof),
      .byte_data (byte_data),
      .last_o    (last_w),
      .addr_o    (addr_w),
      .hash_o    (hash_w)
   );

   daf_decide #(
      .ADDR_W   (ADDR_W),
      .HASH_BITS(HASH_BITS),
      .WORD_W   (WORD_W),
      .TBL_WORDS(TBL_WORDS)
   ) u_dec (
      .clk       (clk),
      .rst_n     (rst_n),
      .last_i    (last_w),
      .addr_i    (addr_w),
      .hash_i    (hash_w),
      .sta_i     (sta_w),
      .promisc_i (promisc_w),
      .tbl_i     (tbl_w),
      .dec_valid (dec_valid),
      .dec_accept(dec_accept)
   );

endmodule

// File: rtl/daf_checker.sv
module daf_checker #(
   parameter int ADDR_BYTES = 6,
   parameter int WORD_W     = 16,
   parameter int HASH_BITS  = 6,
   parameter int CFG_AW     = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_we,
   input logic [CFG_AW-1:0] cfg_addr,
   input logic [WORD_W-1:0] cfg_wdata,
   input logic              byte_valid,
   input logic              byte_sof,
   input logic [7:0]        byte_data,
   input logic              dec_valid,
   input logic              dec_accept
);

   localparam int ADDR_W    = ADDR_BYTES * 8;
   localparam int STA_WORDS = ADDR_W / WORD_W;
   localparam int TBL_BITS  = 1 << HASH_BITS;
   localparam int TBL_WORDS = TBL_BITS / WORD_W;
   localparam int CNT_W     = $clog2(ADDR_BYTES + 1);

   logic [CNT_W-1:0]    ck_cnt;
   logic [ADDR_W-1:0]   ck_addr;
   logic [ADDR_W-1:0]   sh_sta;
   logic                sh_prom;
   logic [TBL_BITS-1:0] sh_tbl;
   logic                ck_last;

   assign ck_last = byte_valid &&
                    (byte_sof ? (ADDR_BYTES == 1) : (ck_cnt == CNT_W'(ADDR_BYTES - 1)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ck_cnt  <= CNT_W'(ADDR_BYTES);
         ck_addr <= '0;
         sh_sta  <= '0;
         sh_prom <= 1'b0;
         sh_tbl  <= '0;
      end else begin
         if (byte_valid && byte_sof) begin
            ck_addr[7:0] <= byte_data;
            ck_cnt       <= CNT_W'(1);
         end else if (byte_valid && ck_cnt < CNT_W'(ADDR_BYTES)) begin
            ck_addr[ck_cnt*8 +: 8] <= byte_data;
            ck_cnt                 <= ck_cnt + CNT_W'(1);
         end
         if (cfg_we) begin
            for (int k = 0; k < STA_WORDS; k++)
               if (cfg_addr == CFG_AW'(k)) sh_sta[k*WORD_W +: WORD_W] <= cfg_wdata;
            if (cfg_addr == CFG_AW'(STA_WORDS)) sh_prom <= cfg_wdata[0];
            for (int k = 0; k < TBL_WORDS; k++)
               if (cfg_addr == CFG_AW'(STA_WORDS + 1 + k))
                  sh_tbl[k*WORD_W +: WORD_W] <= cfg_wdata;
         end
      end
   end

   p_decision_follows_last_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ck_last |=> dec_valid);

   p_decision_has_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
      dec_valid |-> $past(ck_last));

   p_accept_qualified_r2: assert property (@(posedge clk) disable iff (!rst_n)
      dec_accept |-> dec_valid);

   p_unicast_exact_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid && !$past(sh_prom) && !ck_addr[0]) |-> (dec_accept == (ck_addr == $past(sh_sta))));

   p_promisc_accepts_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid && $past(sh_prom)) |-> dec_accept);

   p_full_table_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid && ck_addr[0] && $past(&sh_tbl)) |-> dec_accept);

endmodule

bind dest_addr_filter daf_checker #(
   .ADDR_BYTES(ADDR_BYTES),
   .WORD_W    (WORD_W),
   .HASH_BITS (HASH_BITS),
   .CFG_AW    (CFG_AW)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_we    (cfg_we),
   .cfg_addr  (cfg_addr),
   .cfg_wdata (cfg_wdata),
   .byte_valid(byte_valid),
   .byte_sof  (byte_sof),
   .byte_data (byte_data),
   .dec_valid (dec_valid),
   .dec_accept(dec_accept)
);

// File: tb/tb_dest_addr_filter.sv
module tb_dest_addr_filter;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_addr = '0;
   logic [15:0] cfg_wdata = '0;
   logic        byte_valid = 1'b0;
   logic        byte_sof = 1'b0;
   logic [7:0]  byte_data = '0;
   logic        dec_valid;
   logic        dec_accept;

   always #10 clk = ~clk;

   dest_addr_filter dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .byte_valid(byte_valid), .byte_sof(byte_sof),
      .byte_data(byte_data), .dec_valid(dec_valid), .dec_accept(dec_accept)
   );

   int checks = 0;
   int errors = 0;
   bit done = 0;

   task automatic check(input bit ok, input string tag, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   // behavioural hash: 48 address bits, LSB of byte 0 first
   function automatic int hash6(input logic [47:0] a);
      logic [31:0] c = 32'hFFFF_FFFF;
      for (int i = 0; i < 48; i++) begin
         bit fb = c[0] ^ a[i];
         c = c >> 1;
         if (fb) c = c ^ 32'hEDB8_8320;
      end
      return int'(c[31:26]);
   endfunction

   function automatic bit ref_accept(input logic [47:0] a, input logic [47:0] sta,
                                     input bit prom, input logic [63:0] tbl);
      if (prom) return 1'b1;
      if (a[0]) return tbl[hash6(a)];
      return a == sta;
   endfunction

   // cycle-by-cycle reference model
   int          m_cnt = 6;
   logic [47:0] m_addr = '0;
   logic [47:0] m_sta = '0;
   bit          m_prom = 0;
   logic [63:0] m_tbl = '0;
   bit          m_v = 0;
   bit          m_a = 0;
   string       m_tag = "R3";

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = 6; m_addr = '0; m_sta = '0; m_prom = 0; m_tbl = '0;
         m_v = 0; m_a = 0;
      end else begin
         bit fire;
         fire = 0;
         if (byte_valid) begin
            if (byte_sof) begin
               m_addr[7:0] = byte_data;
               m_cnt = 1;
            end else if (m_cnt < 6) begin
               m_addr[m_cnt*8 +: 8] = byte_data;
               m_cnt++;
               fire = (m_cnt == 6);
            end
         end
         m_v   = fire;
         m_a   = fire && ref_accept(m_addr, m_sta, m_prom, m_tbl);
         m_tag = m_prom ? "R5" : (m_addr[0] ? "R4" : "R3");
         if (cfg_we) begin
            if (cfg_addr < 3) m_sta[cfg_addr*16 +: 16] = cfg_wdata;
            else if (cfg_addr == 3) m_prom = cfg_wdata[0];
            else m_tbl[(cfg_addr-4)*16 +: 16] = cfg_wdata;
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         check(dec_valid === m_v, "R2", "model dec_valid", dec_valid, m_v);
         check(dec_accept === m_a, m_tag, "model dec_accept", dec_accept, m_a);
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic wr(input int a, input logic [15:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = 3'(a); cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic set_tbl(input logic [63:0] t);
      for (int w = 0; w < 4; w++) wr(4 + w, t[w*16 +: 16]);
   endtask

   task automatic send(input logic [47:0] f, input int gap, input bit exp,
                       input string tag, input bit do_wr,
                       input int wa, input logic [15:0] wd);
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         byte_valid = 1'b1; byte_sof = (i == 0); byte_data = f[i*8 +: 8];
         if (i == 5 && do_wr) begin
            cfg_we = 1'b1; cfg_addr = 3'(wa); cfg_wdata = wd;
         end
         if (i < 5)
            for (int g = 0; g < gap; g++) begin
               @(negedge clk);
               byte_valid = 1'b0; byte_sof = 1'b0;
            end
      end
      @(negedge clk);
      byte_valid = 1'b0; byte_sof = 1'b0; cfg_we = 1'b0;
      check(dec_valid === 1'b1, tag, "decision strobe", dec_valid, 1);
      check(dec_accept === exp, tag, "accept", dec_accept, exp);
      @(negedge clk);
      check(dec_valid === 1'b0, "R2", "strobe one cycle", dec_valid, 0);
   endtask

   localparam logic [47:0] STA   = 48'h5544_3322_1102;  // 02:11:22:33:44:55
   localparam logic [47:0] UC_LO = 48'h5644_3322_1102;  // last byte differs
   localparam logic [47:0] UC_HI = 48'h5544_3322_1104;  // first byte differs
   localparam logic [47:0] MC_A  = 48'h0100_005E_0001;  // 01:00:5e:00:00:01
   localparam logic [47:0] MC_B  = 48'h0100_0000_3333;  // 33:33:00:00:00:01
   localparam logic [47:0] BCAST = 48'hFFFF_FFFF_FFFF;

   initial begin
      int ha, hb;
      ha = hash6(MC_A);
      hb = hash6(BCAST);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(dec_valid === 1'b0 && dec_accept === 1'b0, "R1", "outputs after reset",
            {dec_valid, dec_accept}, 0);

      // R1: zeroed configuration
      send(48'h0, 0, 1'b1, "R1", 0, 0, 0);
      send(BCAST, 0, 1'b0, "R1", 0, 0, 0);

      // R3: station match
      wr(0, 16'h1102); wr(1, 16'h3322); wr(2, 16'h5544);
      send(STA,   0, 1'b1, "R3", 0, 0, 0);
      send(UC_LO, 0, 1'b0, "R3", 0, 0, 0);
      send(UC_HI, 0, 1'b0, "R3", 0, 0, 0);
      // R8: idle gaps inside an address
      send(STA,   2, 1'b1, "R8", 0, 0, 0);

      // R4: hash table lookup
      set_tbl(64'd1 << ha);
      send(MC_A, 0, 1'b1, "R4", 0, 0, 0);
      set_tbl(~(64'd1 << ha));
      send(MC_A, 0, 1'b0, "R4", 0, 0, 0);
      set_tbl(64'd1 << hb);
      send(BCAST, 0, 1'b1, "R4", 0, 0, 0);

      // R6: all-ones table
      set_tbl('1);
      send(MC_A,  0, 1'b1, "R6", 0, 0, 0);
      send(MC_B,  1, 1'b1, "R6", 0, 0, 0);
      send(BCAST, 0, 1'b1, "R6", 0, 0, 0);
      send(UC_LO, 0, 1'b0, "R6", 0, 0, 0);

      // R7: write on the decision edge uses the old table
      set_tbl('0);
      send(MC_A, 0, 1'b0, "R7", 1, 4 + ha / 16, 16'hFFFF);
      send(MC_A, 0, 1'b1, "R7", 0, 0, 0);

      // R5: promiscuous
      set_tbl('0);
      wr(3, 16'h0001);
      send(UC_LO, 0, 1'b1, "R5", 0, 0, 0);
      send(MC_B,  0, 1'b1, "R5", 0, 0, 0);
      wr(3, 16'h0000);
      send(UC_LO, 0, 1'b0, "R5", 0, 0, 0);

      // R8: aborted prefix then a fresh start
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         byte_valid = 1'b1; byte_sof = (i == 0); byte_data = UC_LO[i*8 +: 8];
         @(negedge clk);
         byte_valid = 1'b0; byte_sof = 1'b0;
         check(dec_valid === 1'b0, "R8", "no decision on prefix", dec_valid, 0);
      end
      send(STA, 0, 1'b1, "R8", 0, 0, 0);

      // R9: trailing bytes give no second decision
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         byte_valid = 1'b1; byte_sof = 1'b0; byte_data = 8'h5A;
         @(negedge clk);
         byte_valid = 1'b0;
         check(dec_valid === 1'b0, "R9", "no decision on trailing byte", dec_valid, 0);
      end

      repeat (3) @(negedge clk);
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule